// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sample Converter Sequencer and Result Queue

This block controls a shared 12-bit successive-approximation converter that sits behind four sample-and-hold channels. When it is enabled and idle, a trigger makes it strobe the hold stage once, so that all four inputs are captured at the same moment. It then steers the converter multiplexer to each held channel in turn and runs one conversion per channel.

Each result is tagged with the channel it came from and packed into a 16-bit word. The word is queued in a 16-entry FIFO, and the host drains the FIFO whenever it likes. A fast mode keeps the multiplexer on channel 0 and runs a single conversion per trigger. Dropping the enable stops all converter activity.

Top module: `sar_frame_ctrl`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0, `level_o`=0), `ovf_o`=0, `rd_data_o`=0, and neither `sample_o` nor `conv_start_o` is asserted.
- R2: A trigger seen at a clock edge while enabled and idle raises `sample_o` for exactly one cycle after that edge. The first `conv_start_o` pulse follows in the next cycle, and each `conv_start_o` pulse lasts one cycle.
- R3: In normal mode the four channels are converted in ascending order 0, 1, 2, 3. `mux_sel_o` holds the channel number from its `conv_start_o` until that channel's `conv_done_i`.
- R4: Each queued word holds the converter data in bits [11:0] and the channel number in bits [13:12]. Bits [15:14] are always 0.
- R5: A trigger that arrives before channel 3 of the current sequence has been pushed is ignored. It causes no extra sample or conversion.
- R6: In fast mode, which is latched at the accepted trigger, exactly one conversion runs per trigger. `mux_sel_o` is 0 during that conversion, and the word carries channel tag 0.
- R7: While `enable_i` is 0, triggers are ignored. If the enable drops in the middle of a sequence, no further `sample_o` or `conv_start_o` is issued and no further results are queued.
- R8: The queue returns words in the order they were pushed. `level_o` counts the stored words (0 to 16), `empty_o` means a level of 0, and `full_o` means a level of 16.
- R9: A result that arrives while the queue is full is dropped, and the sticky `ovf_o` flag is set. `ovf_o` stays set until a cycle in which `ovf_clr_i`=1.
- R10: A read (`rd_en_i`=1) from an empty queue returns `rd_data_o`=0 and changes neither the level nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| fast_mode_i | input | 1 | 1 = convert channel 0 only |
| trig_i | input | 1 | Sample request |
| sample_o | output | 1 | Hold strobe to all four channels |
| mux_sel_o | output | 2 | Converter multiplexer channel |
| conv_start_o | output | 1 | Converter start pulse |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| rd_en_i | input | 1 | Pop one word from the queue |
| rd_data_o | output | 16 | Word at the head of the queue, 0 when empty |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| level_o | output | 5 | Number of stored words |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears `ovf_o` when 1 |

## Verification
The sequence timing is fixed in cycles:
- `sample_o` is high in the cycle after the edge that accepts the trigger.
- `conv_start_o` is high in the cycle after that.
- The converter is served from the cycle after the start pulse.
- A `conv_done_i` sampled at an edge changes `level_o` and the head word at that same edge.
- A pop takes effect at the edge on which `rd_en_i` is seen.

The bench drives every input on the falling edge and reads the outputs on the following falling edge. Its converter model waits for the start pulse, answers one cycle later and holds `conv_done_i` for a single cycle. Every expected value is therefore read half a cycle after the edge that produced it.

// File: rtl/sar_frame_pkg.sv
package sar_frame_pkg;
  parameter int unsigned DATA_W     = 12;
  parameter int unsigned CH_W       = 2;
  parameter int unsigned WORD_W     = 16;
  parameter int unsigned FIFO_DEPTH = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_START,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_frame_pkg::*;
#(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            fast_mode_i,
  input  logic            trig_i,
  input  logic            conv_done_i,
  output logic            sample_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] mux_sel_o,
  output logic            push_o,
  output logic            fast_q_o
);
  localparam logic [CH_W-1:0] LAST_CH = {CH_W{1'b1}};

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] ch_q;
  logic            fast_q;
  logic            accept, last_done;

  assign accept    = (state_q == ST_IDLE) && enable_i && trig_i;
  assign push_o    = (state_q == ST_WAIT) && enable_i && conv_done_i;
  assign last_done = fast_q || (ch_q == LAST_CH);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = enable_i ? ST_START : ST_IDLE;
      ST_START:  state_d = enable_i ? ST_WAIT : ST_IDLE;
      ST_WAIT: begin
        if (!enable_i)   state_d = ST_IDLE;
        else if (push_o) state_d = last_done ? ST_IDLE : ST_START;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      fast_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ch_q   <= '0;
        fast_q <= fast_mode_i;
      end else if (push_o && !last_done) begin
        ch_q <= ch_q + 1'b1;
      end
    end
  end

  assign sample_o     = (state_q == ST_SAMPLE);
  assign conv_start_o = (state_q == ST_START);
  assign mux_sel_o    = ch_q;
  assign fast_q_o     = fast_q;
endmodule

// File: rtl/sar_result_fifo.sv
module sar_result_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  input  logic             ovf_clr_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o
);
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] cnt_q;
  logic             ovf_q, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LVL_FULL);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + LVL_W'(do_push) - LVL_W'(do_pop);
      // a drop in the same cycle wins over a clear
      if (push_i && full_o) ovf_q <= 1'b1;
      else if (ovf_clr_i)   ovf_q <= 1'b0;
    end
  end

  assign rdata_o = empty_o ? '0 : mem[rd_ptr_q];
  assign level_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
  import sar_frame_pkg::*;
#(
  parameter int unsigned DATA_W = sar_frame_pkg::DATA_W,
  parameter int unsigned CH_W   = sar_frame_pkg::CH_W,
  parameter int unsigned WORD_W = sar_frame_pkg::WORD_W,
  parameter int unsigned DEPTH  = sar_frame_pkg::FIFO_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1),
  localparam int unsigned PAD_W = WORD_W - DATA_W - CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              fast_mode_i,
  input  logic              trig_i,
  output logic              sample_o,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  logic              push, fast_q;
  logic [WORD_W-1:0] word;

  sar_seq_fsm #(.CH_W(CH_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .fast_mode_i  (fast_mode_i),
    .trig_i       (trig_i),
    .conv_done_i  (conv_done_i),
    .sample_o     (sample_o),
    .conv_start_o (conv_start_o),
    .mux_sel_o    (mux_sel_o),
    .push_o       (push),
    .fast_q_o     (fast_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, mux_sel_o, conv_data_i};
    end else begin : g_nopad
      assign word = {mux_sel_o, conv_data_i};
    end
  endgenerate

  sar_result_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .wdata_i   (word),
    .pop_i     (rd_en_i),
    .ovf_clr_i (ovf_clr_i),
    .rdata_o   (rd_data_o),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .level_o   (level_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/sar_frame_chk.sv
module sar_frame_chk #(
  parameter int unsigned CH_W   = 2,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LVL_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              sample_o,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   mux_sel_o,
  input logic              fast_q,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              full_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              ovf_o,
  input logic              ovf_clr_i
);
  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_sample_then_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o && enable_i |=> conv_start_o);

  assert_mux_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> $stable(mux_sel_o));

  assert_pad_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[WORD_W-1:WORD_W-2] == 2'b00);

  assert_fast_ch0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o && fast_q |-> mux_sel_o == '0);

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !conv_start_o && !sample_o);

  assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  assert_full_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rd_en_i |=> full_o);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);
endmodule

bind sar_frame_ctrl sar_frame_chk #(
  .CH_W(CH_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .sample_o     (sample_o),
  .conv_start_o (conv_start_o),
  .mux_sel_o    (mux_sel_o),
  .fast_q       (fast_q),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .full_o       (full_o),
  .level_o      (level_o),
  .ovf_o        (ovf_o),
  .ovf_clr_i    (ovf_clr_i)
);

// File: tb/sar_frame_ctrl_bench.sv
module sar_frame_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, fast = 1'b0, trig = 1'b0;
  logic        sample, conv_start, conv_done = 1'b0;
  logic [1:0]  mux_sel;
  logic [11:0] conv_data = '0;
  logic        rd_en = 1'b0, ovf_clr = 1'b0;
  logic [15:0] rd_data;
  logic        empty, full, ovf;
  logic [4:0]  level;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sar_frame_ctrl u_sar_frame_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .fast_mode_i(fast),
    .trig_i(trig), .sample_o(sample), .mux_sel_o(mux_sel),
    .conv_start_o(conv_start), .conv_done_i(conv_done), .conv_data_i(conv_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_o(empty), .full_o(full),
    .level_o(level), .ovf_o(ovf), .ovf_clr_i(ovf_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // waits up to 40 cycles for conv_start_o; returns whether it was seen
  task automatic wait_start(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (n < 40) begin
      if (conv_start) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic answer(input logic [11:0] d);
    @(negedge clk);
    conv_done = 1'b1;
    conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic count_activity(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (conv_start || sample) hits++;
    end
  endtask

  task automatic pop_expect(input logic [15:0] exp, input string req);
    check(rd_data == exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic flush();
    while (!empty) begin
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  // one normal-mode sequence; data = base + channel
  task automatic normal_seq(input logic [11:0] base);
    bit seen;
    pulse_trig();
    for (int ch = 0; ch < 4; ch++) begin
      wait_start(seen);
      check(seen, "R3 start seen", seen, 1);
      check(mux_sel == 2'(ch), "R3 channel order", mux_sel, ch);
      answer(base + 12'(ch));
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(empty == 1'b1 && full == 1'b0 && level == 5'd0, "R1 queue state", level, 0);
    check(ovf == 1'b0, "R1 ovf", ovf, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
    check(!sample && !conv_start, "R1 idle outputs", {sample, conv_start}, 0);
  endtask

  task automatic t_timing();
    bit seen;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(sample == 1'b1, "R2 sample strobe", sample, 1);
    @(negedge clk);
    check(sample == 1'b0, "R2 sample one cycle", sample, 0);
    check(conv_start == 1'b1, "R2 first start", conv_start, 1);
    @(negedge clk);
    check(conv_start == 1'b0, "R2 start one cycle", conv_start, 0);
    for (int ch = 0; ch < 4; ch++) begin
      wait_start(seen);
      answer(12'h100 + 12'(ch));
    end
    @(negedge clk);
    check(level == 5'd4, "R8 level after sequence", level, 4);
    for (int ch = 0; ch < 4; ch++)
      pop_expect({2'b00, 2'(ch), 12'h100 + 12'(ch)}, "R4 frame");
    check(empty == 1'b1, "R8 empty after drain", empty, 1);
  endtask

  task automatic t_normal_patterns();
    normal_seq(12'hA50);
    normal_seq(12'hFFC);
    check(level == 5'd8, "R8 level two sequences", level, 8);
    for (int ch = 0; ch < 4; ch++)
      pop_expect({2'b00, 2'(ch), 12'hA50 + 12'(ch)}, "R3 R4 first set");
    for (int ch = 0; ch < 4; ch++)
      pop_expect({2'b00, 2'(ch), 12'hFFC + 12'(ch)}, "R8 order second set");
  endtask

  task automatic t_busy_trigger();
    bit seen;
    int hits;
    pulse_trig();
    for (int ch = 0; ch < 4; ch++) begin
      wait_start(seen);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      conv_done = 1'b1;
      conv_data = 12'h300 + 12'(ch);
      @(negedge clk);
      conv_done = 1'b0;
    end
    count_activity(20, hits);
    check(hits == 0, "R5 busy triggers ignored", hits, 0);
    check(level == 5'd4, "R5 exactly four results", level, 4);
    flush();
  endtask

  task automatic t_fast();
    bit seen;
    int hits;
    fast = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pulse_trig();
      wait_start(seen);
      check(seen && mux_sel == 2'd0, "R6 mux on ch0", mux_sel, 0);
      answer(12'h7F0 + 12'(k));
      count_activity(6, hits);
      check(hits == 0, "R6 one conversion per trigger", hits, 0);
    end
    fast = 1'b0;
    check(level == 5'd3, "R6 level", level, 3);
    for (int k = 0; k < 3; k++)
      pop_expect({4'b0000, 12'h7F0 + 12'(k)}, "R6 tag zero");
  endtask

  task automatic t_disable();
    bit seen;
    int hits;
    enable = 1'b0;
    pulse_trig();
    count_activity(20, hits);
    check(hits == 0, "R7 disabled no activity", hits, 0);
    check(level == 5'd0, "R7 disabled no results", level, 0);
    enable = 1'b1;
    pulse_trig();
    wait_start(seen);
    answer(12'h055);
    wait_start(seen);
    enable = 1'b0;
    count_activity(20, hits);
    check(hits == 0, "R7 abort stops sequence", hits, 0);
    conv_done = 1'b1;
    conv_data = 12'h066;
    @(negedge clk);
    conv_done = 1'b0;
    @(negedge clk);
    check(level == 5'd1, "R7 abort no more results", level, 1);
    enable = 1'b1;
    flush();
  endtask

  task automatic t_overflow();
    for (int s = 0; s < 4; s++) normal_seq(12'h800 + 12'(s * 16));
    check(full == 1'b1 && level == 5'd16, "R8 full at 16", level, 16);
    check(ovf == 1'b0, "R9 no ovf yet", ovf, 0);
    normal_seq(12'hEE0);
    check(level == 5'd16, "R9 level held", level, 16);
    check(ovf == 1'b1, "R9 ovf set", ovf, 1);
    for (int s = 0; s < 4; s++)
      for (int ch = 0; ch < 4; ch++)
        pop_expect({2'b00, 2'(ch), 12'h800 + 12'(s * 16 + ch)}, "R9 kept data");
    check(empty == 1'b1, "R8 empty", empty, 1);
    check(ovf == 1'b1, "R9 ovf sticky", ovf, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(ovf == 1'b0, "R9 ovf cleared", ovf, 0);
  endtask

  task automatic t_empty_read();
    rd_en = 1'b1;
    check(rd_data == 16'h0, "R10 empty data", rd_data, 0);
    @(negedge clk);
    rd_en = 1'b0;
    check(level == 5'd0 && empty && !full && !ovf, "R10 state unchanged", level, 0);
    normal_seq(12'h010);
    pop_expect(16'h0010, "R10 queue intact after empty read");
    flush();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    t_timing();
    t_normal_patterns();
    t_busy_trigger();
    t_fast();
    t_disable();
    t_overflow();
    t_empty_read();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule